// File: doc/BRIEF.md
# Serial Event Interrupt and DMA Request Router

The router collects the receive-full and transmit-empty events of four serial channels. That gives eight event sources. Each source is numbered s = 2*channel + dir, where dir is 0 for receive-full and 1 for transmit-empty. For each source the router keeps the following per-source state:

- a sticky pending flag;
- an interrupt enable bit;
- two DMA steering bits;
- a completion-interrupt option;
- a 3-bit priority level.

By default a pending, enabled source competes for the single CPU interrupt line. When both DMA steering bits of a source are set, its event goes to a fixed DMA channel as a one-cycle trigger instead. The CPU interrupt for that source is then raised only when the DMA engine reports that the transfer is complete, and only if the completion option is set.

Configuration is written one source at a time through a write strobe with a source index. Pending flags are cleared by writing 1 to their bits through a clear mask. The CPU side supplies its global interrupt enable and its current interrupt level. The router presents the arbitration winner only when the CPU would take it.

Top module: `irq_dma_router`

## Requirements
- R1: An event on source s sets bit s of `flag_o` on the next clock edge, whatever the interrupt enable of s.
- R2: A source requests an interrupt only while its pending flag and its interrupt enable bit are both 1.
- R3: Among requesting sources the highest level wins, reported on `irq_src_o` and `irq_lvl_o`. On equal levels the lowest source index wins.
- R4: `irq_o` is 1 only when a winner exists, `cpu_ie_i` is 1 and `cpu_il_i` is strictly below the winner's level.
- R5: When a source has both DMA steering bits set (`cfg_dreq_i`, `cfg_den_i`), its event produces a one-cycle `dma_trig_o` on the second clock edge after the event, and no interrupt is requested. At that same edge its flag is cleared. Several such sources are served one per cycle, lowest index first.
- R6: The DMA channel numbers are fixed per source. Sources 0 to 3 map to 0x17, 0x18, 0x19 and 0x1A. Sources 4 to 7 map to 0x22, 0x23, 0x24 and 0x25.
- R7: A pulse on `dma_done_i` whose `dma_done_ch_i` equals the channel number of source s raises a deferred pending flag for s, but only if the completion option of s is set. A completion for another channel, or with the option cleared, leaves every flag and `irq_o` unchanged.
- R8: Writing 1 to bit s of `flag_clr_i` clears both pending flags of s. If an event on s arrives in the same cycle as the clear, the event wins.
- R9: After reset, all flags, all configuration bits, `irq_o` and `dma_trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event strobes, bit s = source s |
| cfg_we_i | input | 1 | Write strobe for the configuration of one source |
| cfg_src_i | input | 3 | Source index to configure |
| cfg_ien_i | input | 1 | Interrupt enable value |
| cfg_dreq_i | input | 1 | DMA request steering bit |
| cfg_den_i | input | 1 | DMA enable steering bit |
| cfg_dint_i | input | 1 | Interrupt-on-completion option |
| cfg_lvl_i | input | 3 | Priority level 0..7 |
| flag_clr_i | input | 8 | Write-1-to-clear mask for the pending flags |
| cpu_ie_i | input | 1 | CPU global interrupt enable |
| cpu_il_i | input | 3 | CPU current interrupt level |
| dma_done_i | input | 1 | DMA transfer complete strobe |
| dma_done_ch_i | input | 6 | Channel number of the completed transfer |
| flag_o | output | 8 | Pending flags (event or deferred completion) |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_src_o | output | 3 | Winning source index |
| irq_lvl_o | output | 3 | Winning level |
| dma_trig_o | output | 1 | One-cycle DMA trigger |
| dma_ch_o | output | 6 | DMA channel number for the trigger |

## Verification
The bench raises an event on a source whose interrupt is disabled, then enables it. A design that gated the flag with the enable would show no pending bit and would never raise the late request. It sets equal levels on several sources and checks that the lowest index wins. A reversed or non-strict comparison would hand the line to the higher index. It also sets the CPU level equal to the winner's level, where a non-strict compare would let the request through.

On the DMA side, every source is steered in turn and the exact channel number is checked in the cycle of the trigger. Two steered sources fire together, so a design that dropped one trigger would show a single pulse where two are expected. Completions are sent for a non-matching channel and with the option cleared, and in both cases no deferred interrupt may appear. A clear that coincides with an event must leave the flag set.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int N_CH  = 4;
  localparam int N_SRC = 2 * N_CH;
  localparam int SRC_W = $clog2(N_SRC);
  localparam int LVL_W = 3;
  localparam int DCH_W = 6;

  typedef struct packed {
    logic             ien;
    logic             dreq;
    logic             den;
    logic             dint;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  // fixed DMA channel map: low half from 0x17, high half from 0x22
  function automatic logic [DCH_W-1:0] dma_chan(input int s);
    int v;
    v = (s < 4) ? (32'h17 + s) : (32'h22 + s - 4);
    return v[DCH_W-1:0];
  endfunction
endpackage

// File: rtl/irq_rt_src.sv
module irq_rt_src
  import irq_rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic             cfg_we_i,
  input  src_cfg_t         cfg_i,
  input  logic             done_hit_i,
  input  logic             dma_take_i,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             dma_want_o,
  output logic             pend_o
);
  src_cfg_t cfg_q;
  logic     flag_q, cmp_q, div;

  assign div = cfg_q.dreq & cfg_q.den;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_i;
      if (evt_i)                    flag_q <= 1'b1;
      else if (clr_i || dma_take_i) flag_q <= 1'b0;
      if (done_hit_i && cfg_q.dint) cmp_q <= 1'b1;
      else if (clr_i)               cmp_q <= 1'b0;
    end
  end

  assign dma_want_o = flag_q & div;
  assign req_o      = cfg_q.ien & ((flag_q & ~div) | cmp_q);
  assign lvl_o      = cfg_q.lvl;
  assign pend_o     = flag_q | cmp_q;
endmodule

// File: rtl/irq_rt_arb.sv
module irq_rt_arb
  import irq_rt_pkg::*;
(
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        vld_o,
  output logic [SRC_W-1:0]            idx_o,
  output logic [LVL_W-1:0]            lvl_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    // strict compare keeps lowest index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!vld_o || lvl_i[i] > lvl_o)) begin
        vld_o = 1'b1;
        idx_o = SRC_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_rt_dma.sv
module irq_rt_dma
  import irq_rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] want_i,
  output logic [N_SRC-1:0] take_o,
  output logic             trig_o,
  output logic [DCH_W-1:0] ch_o
);
  logic [DCH_W-1:0] ch_d;

  always_comb begin
    take_o = '0;
    ch_d   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        take_o = '0;
        take_o[i] = 1'b1;
        ch_d   = dma_chan(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= 1'b0;
      ch_o   <= '0;
    end else begin
      trig_o <= |want_i;
      if (|want_i) ch_o <= ch_d;
    end
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             cfg_we_i,
  input  logic [SRC_W-1:0] cfg_src_i,
  input  logic             cfg_ien_i,
  input  logic             cfg_dreq_i,
  input  logic             cfg_den_i,
  input  logic             cfg_dint_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  input  logic [N_SRC-1:0] flag_clr_i,
  input  logic             cpu_ie_i,
  input  logic [LVL_W-1:0] cpu_il_i,
  input  logic             dma_done_i,
  input  logic [DCH_W-1:0] dma_done_ch_i,
  output logic [N_SRC-1:0] flag_o,
  output logic             irq_o,
  output logic [SRC_W-1:0] irq_src_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             dma_trig_o,
  output logic [DCH_W-1:0] dma_ch_o
);
  src_cfg_t                  cfg_w;
  logic [N_SRC-1:0]          req, want, take;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                      win_vld;

  assign cfg_w = '{ien: cfg_ien_i, dreq: cfg_dreq_i, den: cfg_den_i,
                   dint: cfg_dint_i, lvl: cfg_lvl_i};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic done_hit;
    assign done_hit = dma_done_i && (dma_done_ch_i == dma_chan(s));
    irq_rt_src u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[s]),
      .clr_i      (flag_clr_i[s]),
      .cfg_we_i   (cfg_we_i && (cfg_src_i == SRC_W'(s))),
      .cfg_i      (cfg_w),
      .done_hit_i (done_hit),
      .dma_take_i (take[s]),
      .req_o      (req[s]),
      .lvl_o      (lvl[s]),
      .dma_want_o (want[s]),
      .pend_o     (flag_o[s])
    );
  end

  irq_rt_arb u_arb (
    .req_i (req),
    .lvl_i (lvl),
    .vld_o (win_vld),
    .idx_o (irq_src_o),
    .lvl_o (irq_lvl_o)
  );

  irq_rt_dma u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (want),
    .take_o (take),
    .trig_o (dma_trig_o),
    .ch_o   (dma_ch_o)
  );

  assign irq_o = win_vld && cpu_ie_i && (cpu_il_i < irq_lvl_o);
endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk
  import irq_rt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_i,
  input logic             cpu_ie_i,
  input logic [LVL_W-1:0] cpu_il_i,
  input logic [N_SRC-1:0] flag_o,
  input logic             irq_o,
  input logic [SRC_W-1:0] irq_src_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic             dma_trig_o,
  input logic [DCH_W-1:0] dma_ch_o
);
  p_evt_sets_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i) & ~flag_o) == '0));

  p_irq_has_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o[irq_src_o]);

  p_cpu_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cpu_ie_i && (cpu_il_i < irq_lvl_o)));

  p_chan_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_trig_o |-> (dma_ch_o inside {6'h17, 6'h18, 6'h19, 6'h1A,
                                     6'h22, 6'h23, 6'h24, 6'h25}));
endmodule

bind irq_dma_router irq_rt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .cpu_ie_i   (cpu_ie_i),
  .cpu_il_i   (cpu_il_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .irq_src_o  (irq_src_o),
  .irq_lvl_o  (irq_lvl_o),
  .dma_trig_o (dma_trig_o),
  .dma_ch_o   (dma_ch_o)
);

// File: tb/sim_irq_dma_router.sv
`timescale 1ns/1ps
module sim_irq_dma_router;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_src_i = '0;
  logic       cfg_ien_i = 1'b0, cfg_dreq_i = 1'b0, cfg_den_i = 1'b0, cfg_dint_i = 1'b0;
  logic [2:0] cfg_lvl_i = '0;
  logic [7:0] flag_clr_i = '0;
  logic       cpu_ie_i = 1'b1;
  logic [2:0] cpu_il_i = '0;
  logic       dma_done_i = 1'b0;
  logic [5:0] dma_done_ch_i = '0;
  logic [7:0] flag_o;
  logic       irq_o, dma_trig_o;
  logic [2:0] irq_src_o, irq_lvl_o;
  logic [5:0] dma_ch_o;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_dma_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .cfg_we_i(cfg_we_i),
    .cfg_src_i(cfg_src_i), .cfg_ien_i(cfg_ien_i), .cfg_dreq_i(cfg_dreq_i),
    .cfg_den_i(cfg_den_i), .cfg_dint_i(cfg_dint_i), .cfg_lvl_i(cfg_lvl_i),
    .flag_clr_i(flag_clr_i), .cpu_ie_i(cpu_ie_i), .cpu_il_i(cpu_il_i),
    .dma_done_i(dma_done_i), .dma_done_ch_i(dma_done_ch_i), .flag_o(flag_o),
    .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_lvl_o(irq_lvl_o),
    .dma_trig_o(dma_trig_o), .dma_ch_o(dma_ch_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int s, input bit ien, input bit dr, input bit de,
                     input bit di, input int lv);
    @(negedge clk);
    cfg_we_i = 1; cfg_src_i = 3'(s); cfg_ien_i = ien; cfg_dreq_i = dr;
    cfg_den_i = de; cfg_dint_i = di; cfg_lvl_i = 3'(lv);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic all_off();
    for (int s = 0; s < 8; s++) cfg(s, 0, 0, 0, 0, 0);
    @(negedge clk); flag_clr_i = 8'hFF;
    @(negedge clk); flag_clr_i = '0;
    cpu_ie_i = 1; cpu_il_i = 0;
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk); evt_i = m;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk); flag_clr_i = m;
    @(negedge clk); flag_clr_i = '0;
  endtask

  task automatic done_pulse(input logic [5:0] ch);
    @(negedge clk); dma_done_i = 1; dma_done_ch_i = ch;
    @(negedge clk); dma_done_i = 0;
  endtask

  function automatic logic [5:0] exp_ch(input int s);
    logic [5:0] t [8] = '{6'h17, 6'h18, 6'h19, 6'h1A, 6'h22, 6'h23, 6'h24, 6'h25};
    return t[s];
  endfunction

  task automatic t_reset();
    chk("R9 flags", flag_o, 0);
    chk("R9 irq", irq_o, 0);
    chk("R9 trig", dma_trig_o, 0);
  endtask

  task automatic t_flag_enable();
    all_off();
    cfg(3, 0, 0, 0, 0, 5);
    pulse_evt(8'h08);
    chk("R1 flag set with enable off", flag_o, 8'h08);
    chk("R2 no irq with enable off", irq_o, 0);
    cfg(3, 1, 0, 0, 0, 5);
    chk("R2 irq after enable", irq_o, 1);
    chk("R2 irq source", irq_src_o, 3);
    chk("R2 irq level", irq_lvl_o, 5);
  endtask

  task automatic t_clear();
    clr(8'h08);
    chk("R8 clear flag", flag_o, 0);
    chk("R8 irq gone", irq_o, 0);
    @(negedge clk); evt_i = 8'h08; flag_clr_i = 8'h08;
    @(negedge clk); evt_i = 0; flag_clr_i = 0;
    chk("R8 event wins over clear", flag_o, 8'h08);
    clr(8'h08);
    chk("R8 second clear", flag_o, 0);
  endtask

  task automatic t_arb();
    all_off();
    cfg(1, 1, 0, 0, 0, 4);
    cfg(2, 1, 0, 0, 0, 6);
    cfg(6, 1, 0, 0, 0, 6);
    pulse_evt(8'h46);
    chk("R3 tie lowest index", irq_src_o, 2);
    chk("R3 tie level", irq_lvl_o, 6);
    clr(8'h04);
    chk("R3 next same level", irq_src_o, 6);
    clr(8'h40);
    chk("R3 lower level last", irq_src_o, 1);
    chk("R3 lower level value", irq_lvl_o, 4);
  endtask

  task automatic t_accept();
    all_off();
    cfg(5, 1, 0, 0, 0, 3);
    pulse_evt(8'h20);
    cpu_il_i = 3; #1;
    chk("R4 equal level blocked", irq_o, 0);
    cpu_il_i = 2; #1;
    chk("R4 lower cpu level accepted", irq_o, 1);
    cpu_ie_i = 0; #1;
    chk("R4 global disable blocks", irq_o, 0);
    cpu_ie_i = 1; cpu_il_i = 0;
  endtask

  task automatic t_dma();
    all_off();
    for (int s = 0; s < 8; s++) begin
      cfg(s, 1, 1, 1, 0, 7);
      pulse_evt(8'(1 << s));
      chk("R5 no irq on steered event", irq_o, 0);
      chk("R5 trigger not yet", dma_trig_o, 0);
      @(negedge clk);
      chk("R5 trigger pulse", dma_trig_o, 1);
      chk("R6 channel number", dma_ch_o, exp_ch(s));
      chk("R5 flag cleared", flag_o, 0);
      chk("R5 still no irq", irq_o, 0);
      @(negedge clk);
      chk("R5 single cycle", dma_trig_o, 0);
    end
    pulse_evt(8'h03);
    @(negedge clk);
    chk("R5 first of two", dma_ch_o, 6'h17);
    chk("R5 first trig", dma_trig_o, 1);
    @(negedge clk);
    chk("R5 second of two", dma_ch_o, 6'h18);
    chk("R5 second trig", dma_trig_o, 1);
    @(negedge clk);
    chk("R5 pair done", dma_trig_o, 0);
    cfg(0, 1, 1, 0, 0, 7);
    pulse_evt(8'h01);
    chk("R5 one bit only gives irq", irq_o, 1);
    @(negedge clk);
    chk("R5 one bit only no trig", dma_trig_o, 0);
  endtask

  task automatic t_done();
    all_off();
    cfg(4, 1, 1, 1, 1, 2);
    done_pulse(6'h23);
    chk("R7 other channel no flag", flag_o, 0);
    chk("R7 other channel no irq", irq_o, 0);
    done_pulse(6'h22);
    chk("R7 deferred flag", flag_o, 8'h10);
    chk("R7 deferred irq", irq_o, 1);
    chk("R7 deferred source", irq_src_o, 4);
    clr(8'h10);
    chk("R8 clear deferred", flag_o, 0);
    cfg(4, 1, 1, 1, 0, 2);
    done_pulse(6'h22);
    chk("R7 option off no flag", flag_o, 0);
    chk("R7 option off no irq", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_flag_enable();
    t_clear();
    t_arb();
    t_accept();
    t_dma();
    t_done();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule